// File: doc/BRIEF.md
# Pixel Feature Chain

The block takes a stream of 8-bit pixels qualified by a valid strobe, together with start-of-line and start-of-frame markers. It passes each pixel through a fixed sequence of simple stages, in this order: a two-stream combiner, an offset-then-gain stage, a 3x3 Gaussian smoother, a 3x3 Sobel gradient-magnitude stage and a threshold binarizer. Each stage has its own bypass bit. A bypassed stage still occupies its register slot, so the latency from input to output never changes and the markers stay attached to their pixels.

A second pixel stream arrives on the same valid strobe as the main stream. The combiner merges the two with one of seven operations, chosen by an opcode. A small write-only register port sets the bypass bits, offset, gain, threshold and opcode.

The two neighbourhood stages use a trailing window. The result for the pixel at row r, column c is computed over rows r-2..r and columns c-2..c. Positions before the first row or the first column of the frame count as zero. The stream may contain idle cycles. After the chain fills, a gap-free input produces one output pixel per clock.

Top module: `pixelFeatureChain`

## Requirements
- R1: An input beat accepted at a rising edge appears on the outputs exactly 5 rising edges later (the output registers update at the 5th edge counted from the accepting one), independent of configuration. A gap-free input run therefore yields an equally long gap-free output run.
- R2: outSol and outSof are the inSol and inSof of the same beat, delayed along with its pixel.
- R3: After reset, outValid is 0 and all five stages are bypassed, so each output pixel equals the inPixA of its beat. The reset values are offset 0, gain 0x0100, threshold 128 and opcode 0.
- R4: The combiner uses config address 4, bits [2:0], with these encodings: 0 add saturating at 255; 1 absolute difference; 2 minimum; 3 maximum; 4 AND; 5 OR; 6 XOR; 7 passes A.
- R5: The offset-gain stage computes t = max(0, p + offset), then min(255, floor(t * gain / 256)). The offset is a 9-bit two's complement value at address 1, bits [8:0]. The gain is unsigned 8.8 fixed point at address 2, bits [15:0].
- R6: The Gaussian stage outputs floor((sum of w*k + 8) / 16). The weights k are 1 2 1 / 2 4 2 / 1 2 1, applied over the zero-padded trailing window.
- R7: The Sobel stage outputs min(255, |Gx| + |Gy|). Gx is the right window column minus the left one, weighted 1 2 1 down the column. Gy is the bottom window row minus the top one, weighted 1 2 1 along the row.
- R8: The binarizer outputs 255 when the pixel is greater than or equal to the threshold, and 0 otherwise. The threshold is set at address 3, bits [7:0].
- R9: The bypass bits are at address 0. Bit 0 bypasses the combiner, bit 1 the offset-gain stage, bit 2 the Gaussian, bit 3 the Sobel and bit 4 the binarizer. A bypassed stage passes its input pixel unchanged.
- R10: A write to addresses 5, 6 or 7 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWdata | input | 16 | Configuration write data |
| inValid | input | 1 | Input beat valid |
| inSol | input | 1 | Input beat is first of a line |
| inSof | input | 1 | Input beat is first of a frame |
| inPixA | input | 8 | Main stream pixel |
| inPixB | input | 8 | Second stream pixel, aligned with inPixA |
| outValid | output | 1 | Output beat valid |
| outSol | output | 1 | Output beat is first of a line |
| outSof | output | 1 | Output beat is first of a frame |
| outPix | output | 8 | Output pixel |

## Verification
The properties assume four things about the inputs:
- Markers are raised only on valid beats.
- A frame start is always also a line start.
- Every line of a frame has the same length, no longer than the line buffer.
- Configuration is written only while the chain holds no beats.

The stimulus draws random pixel values and random idle gaps. It drives markers only on valid beats, with fixed line lengths, and writes configuration only after each frame has drained and a margin of idle cycles has passed.

// File: rtl/pfcPkg.sv
package pfcPkg;
  localparam int PIX_W      = 8;
  localparam int CFG_ADDR_W = 3;
  localparam int CFG_DATA_W = 16;
  localparam int NUM_STAGES = 5;

  localparam int BYP_COMB   = 0;
  localparam int BYP_GAIN   = 1;
  localparam int BYP_GAUSS  = 2;
  localparam int BYP_SOBEL  = 3;
  localparam int BYP_THRESH = 4;

  typedef struct packed {
    logic             valid;
    logic             sol;
    logic             sof;
    logic [PIX_W-1:0] pix;
  } beat_t;

  typedef enum logic [2:0] {
    OP_ADDSAT  = 3'd0,
    OP_ABSDIFF = 3'd1,
    OP_MIN     = 3'd2,
    OP_MAX     = 3'd3,
    OP_AND     = 3'd4,
    OP_OR      = 3'd5,
    OP_XOR     = 3'd6,
    OP_PASSA   = 3'd7
  } combOp_t;

  typedef struct packed {
    logic [NUM_STAGES-1:0] bypass;
    logic signed [8:0]     offset;
    logic [15:0]           gain;
    logic [PIX_W-1:0]      thresh;
    combOp_t               op;
  } chainCfg_t;
endpackage

// File: rtl/pfcControl.sv
module pfcControl
  import pfcPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [CFG_DATA_W-1:0] cfgWdata,
  output chainCfg_t             cfg
);
  chainCfg_t cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg.bypass <= '1;
      cfgReg.offset <= '0;
      cfgReg.gain   <= 16'h0100;
      cfgReg.thresh <= 8'd128;
      cfgReg.op     <= OP_ADDSAT;
    end else if (cfgWe) begin
      case (cfgAddr)
        3'd0:    cfgReg.bypass <= cfgWdata[NUM_STAGES-1:0];
        3'd1:    cfgReg.offset <= cfgWdata[8:0];
        3'd2:    cfgReg.gain   <= cfgWdata;
        3'd3:    cfgReg.thresh <= cfgWdata[PIX_W-1:0];
        3'd4:    cfgReg.op     <= combOp_t'(cfgWdata[2:0]);
        default: ;
      endcase
    end
  end

  assign cfg = cfgReg;
endmodule

// File: rtl/pfcWindowStage.sv
module pfcWindowStage
  import pfcPkg::*;
#(
  parameter int LINE_W   = 16,
  parameter bit IS_SOBEL = 1'b0
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  bypass,
  input  beat_t inBeat,
  output beat_t outBeat
);
  localparam int COL_W = $clog2(LINE_W);

  logic [PIX_W-1:0] lineUp1 [LINE_W];
  logic [PIX_W-1:0] lineUp2 [LINE_W];
  logic [PIX_W-1:0] colPrev1 [3];
  logic [PIX_W-1:0] colPrev2 [3];
  logic [COL_W-1:0] colReg, curCol;
  logic [1:0]       lvlReg, curLvl;
  logic [PIX_W-1:0] w [3][3];
  logic [PIX_W-1:0] result;

  always_comb begin
    curCol = inBeat.sol ? '0 : colReg;
    if (inBeat.sof)      curLvl = 2'd0;
    else if (inBeat.sol) curLvl = (lvlReg == 2'd2) ? 2'd2 : lvlReg + 2'd1;
    else                 curLvl = lvlReg;
    w[0][2] = (curLvl == 2'd2) ? lineUp2[curCol] : '0;
    w[1][2] = (curLvl != 2'd0) ? lineUp1[curCol] : '0;
    w[2][2] = inBeat.pix;
    for (int i = 0; i < 3; i++) begin
      w[i][1] = (curCol >= COL_W'(1)) ? colPrev1[i] : '0;
      w[i][0] = (curCol >= COL_W'(2)) ? colPrev2[i] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (inBeat.valid) begin
      lineUp1[curCol] <= inBeat.pix;
      lineUp2[curCol] <= lineUp1[curCol];
      for (int i = 0; i < 3; i++) begin
        colPrev1[i] <= w[i][2];
        colPrev2[i] <= colPrev1[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg <= '0;
      lvlReg <= '0;
    end else if (inBeat.valid) begin
      colReg <= curCol + COL_W'(1);
      lvlReg <= curLvl;
    end
  end

  function automatic logic signed [11:0] ext(input logic [PIX_W-1:0] p);
    return signed'({4'b0000, p});
  endfunction

  if (IS_SOBEL) begin : gSobel
    logic signed [11:0] gx, gy;
    logic [11:0]        mag;
    always_comb begin
      gx = ext(w[0][2]) + (ext(w[1][2]) <<< 1) + ext(w[2][2])
         - ext(w[0][0]) - (ext(w[1][0]) <<< 1) - ext(w[2][0]);
      gy = ext(w[2][0]) + (ext(w[2][1]) <<< 1) + ext(w[2][2])
         - ext(w[0][0]) - (ext(w[0][1]) <<< 1) - ext(w[0][2]);
      mag = 12'(gx < 0 ? -gx : gx) + 12'(gy < 0 ? -gy : gy);
      result = (mag > 12'd255) ? 8'hFF : 8'(mag);
    end
  end else begin : gGauss
    logic [11:0] gsum;
    always_comb begin
      gsum = 12'd8;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          gsum = gsum + (12'(w[i][j]) << ((i == 1 ? 1 : 0) + (j == 1 ? 1 : 0)));
      result = 8'(gsum >> 4);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBeat <= '0;
    else begin
      outBeat.valid <= inBeat.valid;
      outBeat.sol   <= inBeat.sol;
      outBeat.sof   <= inBeat.sof;
      outBeat.pix   <= bypass ? inBeat.pix : result;
    end
  end
endmodule

// File: rtl/pfcDatapath.sv
module pfcDatapath
  import pfcPkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainCfg_t        cfg,
  input  beat_t            inBeat,
  input  logic [PIX_W-1:0] pixB,
  output beat_t            outBeat
);
  beat_t combBeat, gainBeat, gaussBeat, sobelBeat, threshBeat;
  logic [PIX_W-1:0] combRes, gainRes;

  function automatic logic [PIX_W-1:0] combine(input combOp_t op,
                                                input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    case (op)
      OP_ADDSAT:  return s[PIX_W] ? '1 : s[PIX_W-1:0];
      OP_ABSDIFF: return (a > b) ? a - b : b - a;
      OP_MIN:     return (a < b) ? a : b;
      OP_MAX:     return (a > b) ? a : b;
      OP_AND:     return a & b;
      OP_OR:      return a | b;
      OP_XOR:     return a ^ b;
      default:    return a;
    endcase
  endfunction

  always_comb combRes = combine(cfg.op, inBeat.pix, pixB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) combBeat <= '0;
    else begin
      combBeat     <= inBeat;
      combBeat.pix <= cfg.bypass[BYP_COMB] ? inBeat.pix : combRes;
    end
  end

  logic signed [9:0] offSum;
  logic [8:0]        offClip;
  logic [24:0]       prod;
  always_comb begin
    offSum  = signed'({2'b00, combBeat.pix}) + {cfg.offset[8], cfg.offset};
    offClip = (offSum < 0) ? '0 : offSum[8:0];
    prod    = 25'(offClip) * 25'(cfg.gain);
    gainRes = ((prod >> 8) > 25'd255) ? 8'hFF : 8'(prod >> 8);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gainBeat <= '0;
    else begin
      gainBeat     <= combBeat;
      gainBeat.pix <= cfg.bypass[BYP_GAIN] ? combBeat.pix : gainRes;
    end
  end

  pfcWindowStage #(.LINE_W(LINE_W), .IS_SOBEL(1'b0)) uGauss (
    .clk(clk), .rstN(rstN), .bypass(cfg.bypass[BYP_GAUSS]),
    .inBeat(gainBeat), .outBeat(gaussBeat));

  pfcWindowStage #(.LINE_W(LINE_W), .IS_SOBEL(1'b1)) uSobel (
    .clk(clk), .rstN(rstN), .bypass(cfg.bypass[BYP_SOBEL]),
    .inBeat(gaussBeat), .outBeat(sobelBeat));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) threshBeat <= '0;
    else begin
      threshBeat     <= sobelBeat;
      threshBeat.pix <= cfg.bypass[BYP_THRESH] ? sobelBeat.pix
                      : ((sobelBeat.pix >= cfg.thresh) ? '1 : '0);
    end
  end

  assign outBeat = threshBeat;
endmodule

// File: rtl/pixelFeatureChain.sv
module pixelFeatureChain
  import pfcPkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [CFG_DATA_W-1:0] cfgWdata,
  input  logic                  inValid,
  input  logic                  inSol,
  input  logic                  inSof,
  input  logic [PIX_W-1:0]      inPixA,
  input  logic [PIX_W-1:0]      inPixB,
  output logic                  outValid,
  output logic                  outSol,
  output logic                  outSof,
  output logic [PIX_W-1:0]      outPix
);
  chainCfg_t cfgBus;
  beat_t     inBeat, tailBeat;

  assign inBeat = '{valid: inValid, sol: inSol, sof: inSof, pix: inPixA};

  pfcControl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfg(cfgBus));

  pfcDatapath #(.LINE_W(LINE_W)) uPath (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .inBeat(inBeat),
    .pixB(inPixB), .outBeat(tailBeat));

  assign outValid = tailBeat.valid;
  assign outSol   = tailBeat.sol;
  assign outSof   = tailBeat.sof;
  assign outPix   = tailBeat.pix;
endmodule

// File: rtl/pfcChecker.sv
module pfcChecker
  import pfcPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inSol,
  input logic             inSof,
  input logic             outValid,
  input logic             outSol,
  input logic             outSof,
  input logic [PIX_W-1:0] outPix,
  input chainCfg_t        cfg
);
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd5) sinceRst <= sinceRst + 3'd1;
  end

  a_r1_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd5) |-> (outValid == $past(inValid, 5)));

  a_r2_markers_follow: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd5) |-> (outSol == $past(inSol, 5) && outSof == $past(inSof, 5)));

  a_r2_markers_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outSol || outSof) |-> outValid);

  a_r2_frame_starts_line: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outSol);

  a_r8_binary_levels: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 3'd0 && outValid && !$past(cfg.bypass[BYP_THRESH]))
      |-> (outPix == 8'h00 || outPix == 8'hFF));
endmodule

bind pixelFeatureChain pfcChecker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSol(inSol), .inSof(inSof),
  .outValid(outValid), .outSol(outSol), .outSof(outSof), .outPix(outPix),
  .cfg(cfgBus));

// File: tb/pixelFeatureChain_test.sv
module pixelFeatureChain_test;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cfgWe, inValid, inSol, inSof, outValid, outSol, outSof;
  logic [2:0] cfgAddr;
  logic [15:0] cfgWdata;
  logic [7:0] inPixA, inPixB, outPix;

  pixelFeatureChain #(.LINE_W(LW)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inValid(inValid), .inSol(inSol), .inSof(inSof), .inPixA(inPixA), .inPixB(inPixB),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outPix(outPix));

  int checks = 0, errors = 0;
  string curReq = "R3";
  int mByp = 31, mOff = 0, mGain = 256, mThr = 128, mOp = 0;
  int frA[16][16], frB[16][16];
  int s2[16][16], s3[16][16];
  typedef struct { int pix; bit sol; bit sof; } expBeat_t;
  expBeat_t expQ[$];
  bit monEn = 0;
  int cyc = 0, firstOut = -1, lastOut = -1, outCount = 0;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    expBeat_t e;
    cyc++;
    if (monEn && rstN && outValid) begin
      if (firstOut < 0) firstOut = cyc;
      lastOut = cyc;
      outCount++;
      if (expQ.size() == 0) check(curReq, 1, 0, "unexpected output beat");
      else begin
        e = expQ.pop_front();
        check(curReq, int'(outPix), e.pix, "pixel");
        check("R2", int'({outSol, outSof}), int'({e.sol, e.sof}), "markers");
      end
    end
  end

  function automatic int sat8(int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  function automatic int combF(int a, int b);
    case (mOp)
      0: return sat8(a + b);
      1: return a > b ? a - b : b - a;
      2: return a < b ? a : b;
      3: return a > b ? a : b;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic int gainF(int p);
    int t;
    t = p + mOff;
    if (t < 0) t = 0;
    return sat8((t * mGain) >>> 8);
  endfunction

  function automatic int px(int which, int r, int c);
    if (r < 0 || c < 0) return 0;
    return which == 0 ? s2[r][c] : s3[r][c];
  endfunction

  function automatic int kw(int i);
    return i == 1 ? 2 : 1;
  endfunction

  function automatic int gaussF(int r, int c);
    int s;
    s = 8;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += kw(i) * kw(j) * px(0, r - 2 + i, c - 2 + j);
    return s >>> 4;
  endfunction

  function automatic int sobelF(int r, int c);
    int gx, gy;
    gx = 0; gy = 0;
    for (int i = 0; i < 3; i++) begin
      gx += kw(i) * (px(1, r - 2 + i, c) - px(1, r - 2 + i, c - 2));
      gy += kw(i) * (px(1, r, c - 2 + i) - px(1, r - 2, c - 2 + i));
    end
    if (gx < 0) gx = -gx;
    if (gy < 0) gy = -gy;
    return sat8(gx + gy);
  endfunction

  task automatic buildExpected(int nR, int nC);
    expBeat_t e;
    for (int r = 0; r < nR; r++)
      for (int c = 0; c < nC; c++) begin
        int v;
        v = mByp[0] ? frA[r][c] : combF(frA[r][c], frB[r][c]);
        s2[r][c] = mByp[1] ? v : gainF(v);
      end
    for (int r = 0; r < nR; r++)
      for (int c = 0; c < nC; c++)
        s3[r][c] = mByp[2] ? s2[r][c] : gaussF(r, c);
    for (int r = 0; r < nR; r++)
      for (int c = 0; c < nC; c++) begin
        int v;
        v = mByp[3] ? s3[r][c] : sobelF(r, c);
        if (!mByp[4]) v = (v >= mThr) ? 255 : 0;
        e.pix = v; e.sol = (c == 0); e.sof = (r == 0 && c == 0);
        expQ.push_back(e);
      end
  endtask

  task automatic fillRandom(int nR, int nC);
    for (int r = 0; r < nR; r++)
      for (int c = 0; c < nC; c++) begin
        frA[r][c] = $urandom_range(255);
        frB[r][c] = $urandom_range(255);
      end
  endtask

  task automatic runFrame(string req, int nR, int nC, int gapPct);
    curReq = req;
    buildExpected(nR, nC);
    for (int r = 0; r < nR; r++)
      for (int c = 0; c < nC; c++) begin
        while ($urandom_range(99) < gapPct) begin
          @(negedge clk);
          inValid = 0; inSol = 0; inSof = 0;
        end
        @(negedge clk);
        inValid = 1; inSol = (c == 0); inSof = (r == 0 && c == 0);
        inPixA = 8'(frA[r][c]); inPixB = 8'(frB[r][c]);
      end
    @(negedge clk);
    inValid = 0; inSol = 0; inSof = 0;
    repeat (10) @(negedge clk);
    check(req, expQ.size(), 0, "beats still expected after drain");
  endtask

  task automatic cfgWrite(int addr, int data);
    @(negedge clk);
    cfgWe = 1; cfgAddr = 3'(addr); cfgWdata = 16'(data);
    @(negedge clk);
    cfgWe = 0;
    case (addr)
      0: mByp = data & 31;
      1: mOff = (data & 256) ? (data & 511) - 512 : (data & 511);
      2: mGain = data & 65535;
      3: mThr = data & 255;
      4: mOp = data & 7;
      default: ;
    endcase
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd4242));
    rstN = 0; cfgWe = 0; cfgAddr = 0; cfgWdata = 0;
    inValid = 0; inSol = 0; inSof = 0; inPixA = 0; inPixB = 0;
    repeat (3) @(negedge clk);
    check("R3", int'(outValid), 0, "valid in reset");
    rstN = 1;
    @(negedge clk);
    check("R3", int'(outValid), 0, "valid after reset");
    monEn = 1;

    // R3/R9: default configuration passes inPixA untouched
    fillRandom(4, LW);
    runFrame("R3", 4, LW, 20);

    // R10: writes to unused addresses leave configuration alone
    cfgWrite(5, 16'h0000); cfgWrite(6, 16'hFFFF); cfgWrite(7, 16'h1234);
    fillRandom(3, LW);
    runFrame("R10", 3, LW, 10);

    // R5: offset then gain, including clamp below zero and saturation
    cfgWrite(0, 5'b11101);
    cfgWrite(1, (-20) & 511); cfgWrite(2, 16'h0180);
    fillRandom(3, LW); frA[0][0] = 5; frA[0][1] = 255;
    runFrame("R5", 3, LW, 10);
    cfgWrite(1, 100); cfgWrite(2, 16'h0200);
    fillRandom(2, LW);
    runFrame("R5", 2, LW, 0);

    // R4: every combiner opcode
    cfgWrite(0, 5'b11110);
    for (int op = 0; op < 8; op++) begin
      cfgWrite(4, op);
      fillRandom(2, LW);
      frA[0][0] = 200; frB[0][0] = 100;
      runFrame("R4", 2, LW, 15);
    end

    // R6: Gaussian on random and flat-white frames
    cfgWrite(0, 5'b11011);
    fillRandom(5, LW);
    runFrame("R6", 5, LW, 20);
    for (int r = 0; r < 4; r++) for (int c = 0; c < LW; c++) frA[r][c] = 255;
    runFrame("R6", 4, LW, 0);

    // R7: Sobel on a hard vertical edge and random data
    cfgWrite(0, 5'b10111);
    for (int r = 0; r < 4; r++) for (int c = 0; c < LW; c++) frA[r][c] = (c < 8) ? 0 : 255;
    runFrame("R7", 4, LW, 0);
    fillRandom(4, LW);
    runFrame("R7", 4, LW, 25);

    // R8: threshold boundary 127/128/129
    cfgWrite(0, 5'b01111);
    for (int r = 0; r < 2; r++) for (int c = 0; c < LW; c++) frA[r][c] = 120 + c;
    runFrame("R8", 2, LW, 0);
    cfgWrite(3, 0);
    fillRandom(2, LW);
    runFrame("R8", 2, LW, 0);

    // R9/R1/R2: full chain with gaps
    cfgWrite(0, 0); cfgWrite(4, 1); cfgWrite(1, 10);
    cfgWrite(2, 16'h0140); cfgWrite(3, 40);
    fillRandom(6, LW);
    runFrame("R9", 6, LW, 30);

    // R1: gap-free input gives gap-free output
    firstOut = -1; lastOut = -1; outCount = 0;
    fillRandom(4, LW);
    runFrame("R1", 4, LW, 0);
    check("R1", lastOut - firstOut + 1, 4 * LW, "output run length");
    check("R1", outCount, 4 * LW, "output beat count");

    // R1: latency of a single beat
    fillRandom(1, 1);
    curReq = "R1";
    buildExpected(1, 1);
    @(negedge clk);
    inValid = 1; inSol = 1; inSof = 1;
    inPixA = 8'(frA[0][0]); inPixB = 8'(frB[0][0]);
    lat = -1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      inValid = 0; inSol = 0; inSof = 0;
      if (outValid && lat < 0) lat = k;
    end
    check("R1", lat, 5, "latency in cycles");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule